// File: doc/BRIEF.md
# System Control Port with Bit Set/Reset

This block is a group of byte-wide ports on a simple local I/O bus. It has four addresses. Port A is an input port that always returns a fixed byte. Port B is a status port: seven of its bits are fixed, and bit 0 follows an external serial data line. Port C is a read/write output register. Software can load port C as a whole byte, or change one of its bits through a separate control address.

The current value of port C is always visible on an output bus. Attached functions, such as a speaker gate, take their control bits from that bus. A shutdown flag is high whenever port C bits 7 and 5 are both set.

Writes take effect at the clock edge on which they are presented. Reads are registered. The data comes back one cycle later, marked by a one-cycle valid pulse. The bus has no back-pressure: every read is answered and every write is accepted.

Top module: `sysctl_port`

## Requirements
- R1: A read of address 0 (port A) returns 0x73.
- R2: A read of address 1 (port B) returns 0xF8 with bit 0 replaced by the `serial_din` level sampled on the read cycle.
- R3: A write to address 2 (port C) loads `bus_wdata` into port C. The new value appears on `portc_out` after that clock edge.
- R4: A write to address 3 (control) with data bit 7 clear changes exactly one port C bit. Data bits 3:1 give the bit index. The bit is set when data bit 0 is 1 and cleared when data bit 0 is 0. All other port C bits keep their value.
- R5: A write to address 3 with data bit 7 set leaves port C unchanged.
- R6: `shutdown` is 1 exactly when `portc_out` bits 7 and 5 are both 1.
- R7: After reset, port C holds 0xFF, `bus_rvalid` is 0 and `bus_rdata` is 0x00.
- R8: A read is answered on the next cycle. `bus_rvalid` is high for one cycle, and `bus_rdata` holds the addressed port's value. A read of address 2 returns the port C value held before that edge.
- R9: Writes to address 0 or 1 leave port C unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Port address: 0 port A, 1 port B, 2 port C, 3 control |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| serial_din | input | 1 | External serial data bit shown in port B bit 0 |
| bus_rdata | output | 8 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata carries read data |
| portc_out | output | 8 | Current port C value |
| shutdown | output | 1 | High when port C bits 7 and 5 are both set |

## Verification
A write presented before clock edge k shows on `portc_out` and `shutdown` right after edge k, because there is one register and then combinational logic. The bench drives on the falling edge and checks on the next falling edge. A read presented before edge k returns its data and the valid pulse after edge k. The bench therefore samples `bus_rdata` on the falling edge that follows the strobe, before the next rising edge clears `bus_rvalid`. The control address is swept over all 256 data values. Each value starts from its own seeded port C value, and the expected byte is computed arithmetically.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {
    SEL_FIXED  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_PORTC  = 2'd2,
    SEL_CTRL   = 2'd3
  } port_sel_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              wr_portc,
  output logic              wr_ctrl
);
  port_sel_e sel;

  always_comb begin
    sel      = port_sel_e'(addr);
    wr_portc = wr && (sel == SEL_PORTC);
    wr_ctrl  = wr && (sel == SEL_CTRL);
  end
endmodule

// File: rtl/sysctl_portc.sv
module sysctl_portc #(
  parameter int          DATA_W  = 8,
  parameter logic [DATA_W-1:0] RST_VAL = 8'hFF,
  localparam int         IDX_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_full,
  input  logic [DATA_W-1:0] full_val,
  input  logic              ctrl_wr,
  input  logic              ctrl_group,
  input  logic [IDX_W-1:0]  ctrl_idx,
  input  logic              ctrl_level,
  output logic [DATA_W-1:0] portc_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      portc_q <= RST_VAL;
    end else if (load_full) begin
      portc_q <= full_val;
    end else if (ctrl_wr && !ctrl_group) begin
      portc_q[ctrl_idx] <= ctrl_level;
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 2,
  parameter logic [DATA_W-1:0] FIXED_A   = 8'h73,
  parameter logic [DATA_W-1:0] STATUS_HI = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              serial_bit,
  input  logic [DATA_W-1:0] portc_q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    unique case (port_sel_e'(addr))
      SEL_FIXED:  rd_next = FIXED_A;
      SEL_STATUS: rd_next = {STATUS_HI[DATA_W-1:1], serial_bit};
      SEL_PORTC:  rd_next = portc_q;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/sysctl_port.sv
module sysctl_port #(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 2,
  parameter logic [DATA_W-1:0] PORTC_RST = 8'hFF,
  parameter int                SHUT_HI  = 7,
  parameter int                SHUT_LO  = 5,
  localparam int               IDX_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              serial_din,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] portc_out,
  output logic              shutdown
);
  logic wr_portc;
  logic wr_ctrl;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .wr_portc (wr_portc),
    .wr_ctrl  (wr_ctrl)
  );

  sysctl_portc #(.DATA_W(DATA_W), .RST_VAL(PORTC_RST)) u_portc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_full  (wr_portc),
    .full_val   (bus_wdata),
    .ctrl_wr    (wr_ctrl),
    .ctrl_group (bus_wdata[DATA_W-1]),
    .ctrl_idx   (bus_wdata[IDX_W:1]),
    .ctrl_level (bus_wdata[0]),
    .portc_q    (portc_out)
  );

  sysctl_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (bus_rd),
    .addr       (bus_addr),
    .serial_bit (serial_din),
    .portc_q    (portc_out),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid)
  );

  assign shutdown = portc_out[SHUT_HI] & portc_out[SHUT_LO];
endmodule

// File: rtl/sysctl_port_chk.sv
module sysctl_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic       serial_din,
  input logic [7:0] bus_rdata,
  input logic       bus_rvalid,
  input logic [7:0] portc_out,
  input logic       shutdown
);
  AST_FULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd2 |=> portc_out == $past(bus_wdata)); // R3
  AST_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd3 && !bus_wdata[7]
    |=> portc_out[$past(bus_wdata[3:1])] == $past(bus_wdata[0])); // R4
  AST_BIT_ONLY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd3 && !bus_wdata[7]
    |=> $countones(portc_out ^ $past(portc_out)) <= 1); // R4
  AST_GROUP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd3 && bus_wdata[7] |=> $stable(portc_out)); // R5
  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr[1] |=> $stable(portc_out)); // R9
  AST_SHUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown == (portc_out[7] && portc_out[5])); // R6
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid); // R8
  AST_RD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd0 |=> bus_rdata == 8'h73); // R1
  AST_RD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == 2'd1 |=> bus_rdata == {7'b1111100, $past(serial_din)}); // R2
endmodule

bind sysctl_port sysctl_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .serial_din(serial_din),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .portc_out(portc_out),
  .shutdown(shutdown)
);

// File: tb/sysctl_port_tb_top.sv
module sysctl_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       serial_din = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_rvalid;
  logic [7:0] portc_out;
  logic       shutdown;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .serial_din(serial_din),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .portc_out(portc_out),
    .shutdown(shutdown)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check("R8 rvalid", {31'd0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  function automatic logic [7:0] ctrl_expect(logic [7:0] prev, logic [7:0] v);
    logic [7:0] r;
    r = prev;
    if (v < 8'd128) begin
      if (v % 2 == 1) r = prev | (8'd1 << ((v / 2) % 8));
      else            r = prev & ~(8'd1 << ((v / 2) % 8));
    end
    return r;
  endfunction

  initial begin
    logic [7:0] rd;
    logic [7:0] seed;
    logic [7:0] exp;
    #(CLK_PERIOD * 2);
    // R7 reset state
    check("R7 portc reset", {24'd0, portc_out}, 32'hFF);
    check("R7 rvalid reset", {31'd0, bus_rvalid}, 32'd0);
    check("R7 rdata reset", {24'd0, bus_rdata}, 32'd0);
    check("R6 shutdown at reset", {31'd0, shutdown}, 32'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R8 no read no valid", {31'd0, bus_rvalid}, 32'd0);

    bus_read(2'd0, rd);
    check("R1 port A", {24'd0, rd}, 32'h73);
    for (int s = 0; s < 2; s++) begin
      serial_din = s[0];
      bus_read(2'd1, rd);
      check("R2 port B", {24'd0, rd}, 32'hF8 | s);
    end

    // R3, R6: full writes of every value
    for (int v = 0; v < 256; v++) begin
      bus_write(2'd2, v[7:0]);
      check("R3 full write", {24'd0, portc_out}, v);
      check("R6 shutdown", {31'd0, shutdown}, {31'd0, v[7] & v[5]});
      if (v % 32 == 7) begin
        bus_read(2'd2, rd);
        check("R8 port C readback", {24'd0, rd}, v);
      end
    end

    // R4, R5: control sweep from seeded states
    for (int v = 0; v < 256; v++) begin
      seed = 8'((v * 37) ^ 8'hA5);
      bus_write(2'd2, seed);
      bus_write(2'd3, v[7:0]);
      exp = ctrl_expect(seed, v[7:0]);
      check(v < 128 ? "R4 bit set/reset" : "R5 group ignored", {24'd0, portc_out}, {24'd0, exp});
      check("R6 shutdown after ctrl", {31'd0, shutdown}, {31'd0, exp[7] & exp[5]});
    end

    // R9: writes to ports A and B ignored
    bus_write(2'd2, 8'h5A);
    for (int v = 0; v < 256; v += 17) begin
      bus_write(2'd0, v[7:0]);
      bus_write(2'd1, ~v[7:0]);
      bus_read(2'd2, rd);
      check("R9 read-only addr write", {24'd0, rd}, 32'h5A);
    end

    // R8: read and write of port C in same cycle returns old value
    @(negedge clk);
    bus_addr = 2'd2; bus_wdata = 8'h3C; bus_wr = 1'b1; bus_rd = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R8 same-cycle old value", {24'd0, bus_rdata}, 32'h5A);
    check("R3 same-cycle write lands", {24'd0, portc_out}, 32'h3C);

    // R7: reset again restores 0xFF
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R7 portc after reset", {24'd0, portc_out}, 32'hFF);
    rst_n = 1'b1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule